// File: doc/BRIEF.md
# Baudot Keyboard Shift Sequencer

This block sits on the keyboard side of a five-bit teleprinter interface. It takes 7-bit ASCII key codes through a valid/ready handshake and converts each one with an internal lookup into a 5-bit Baudot code. The lookup also gives two class bits: one says the character exists only in the figures case, the other says it is the same in both cases. The block keeps the current case (letters or figures) in a shift register. Its value is exported so that the printer side can share it.

A key is taken only in a delivery slot, which is a cycle where `slot_i` is high. If the character's case matches the current shift, or it is valid in both cases, its code goes straight into the host buffer. Otherwise the block first delivers the case-change code: FIGURES is 27 and LETTERS is 31. It flips the shift register and keeps the real character in a pending slot. That character is delivered at the next slot, before any new key is accepted. Every delivery loads the buffer and sets a ready flag. The host tests the flag, which is the skip condition, and clears it with a read pulse while it reads the buffer.

The controller has two states. `ST_IDLE` means nothing is pending and keys may be accepted. `ST_HOLD` means a character is waiting behind a case change. The transitions are as follows:
- `ST_IDLE` goes to `ST_HOLD` when a wrong-case key is accepted.
- `ST_HOLD` goes to `ST_IDLE` when a slot delivers the held character.
- Every other cycle keeps the current state.

Top module: `baudot_kbd_seq`

## Requirements
- R1: After reset, the ready flag is 0, the buffer is 0, the shift state is letters (0), the controller is idle, and `key_ready_o` is 0 while `slot_i` is low.
- R2: In the letters case, a letters-only key accepted in a slot is delivered directly. The buffer holds its code and the ready flag is 1 after that clock edge. Key 'E' (0x45) gives code 16 and 'T' (0x54) gives code 1.
- R3: Lower-case letters give the same code as upper case: 'e' (0x65) gives 16.
- R4: A key with no translation, such as '@' (0x40), is consumed with no effect. It does not change the buffer, the ready flag or the shift state.
- R5: Space (0x20) gives 4, carriage return (0x0D) gives 2 and line feed (0x0A) gives 8. These are delivered directly in either case and never change the shift state.
- R6: A figures-only key accepted in the letters case first delivers FIGURES (27) and sets the shift state to 1. The held code is delivered at the next slot. '3' (0x33) is held as 16 and '5' (0x35) is code 1.
- R7: A letters-only key accepted in the figures case first delivers LETTERS (31) and sets the shift state to 0. The held code is delivered at the next slot.
- R8: While a character is held, `key_ready_o` is 0 and a presented key is not accepted. That slot delivers the held code, and the key is accepted at a later slot.
- R9: A read pulse clears the ready flag. If a delivery happens in the same cycle as the read pulse, the flag stays set.
- R10: No key is accepted and nothing is delivered in a cycle where `slot_i` is low.
- R11: The shift state persists, so a second figures-only key in the figures case is delivered directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_i | input | 1 | Delivery slot strobe |
| key_valid_i | input | 1 | A key code is offered |
| key_code_i | input | 7 | ASCII key code |
| key_ready_o | output | 1 | The key is taken this cycle if valid |
| rd_i | input | 1 | Host read pulse, clears the ready flag |
| data_o | output | 5 | Host buffer, 5-bit Baudot code |
| ready_flag_o | output | 1 | A code has been delivered and not yet read |
| shift_fig_o | output | 1 | Shared case state, 1 = figures |

## Verification
The hardest state to reach is a held character that meets a newly offered key in the same slot. That requires a case change first. The bench drives a letters key right after figures traffic, and then in the very next slot offers a different key alongside the held one. It checks that the held code wins, that the new key stays stalled with `key_ready_o` low, and that the new key enters one slot later. A read pulse is also made to coincide with a delivery, to check that the flag stays set.

// File: rtl/baudot_pkg.sv
package baudot_pkg;
    localparam int CODE_W = 5;
    localparam int KEY_W  = 7;

    localparam logic [CODE_W-1:0] FIGS_CODE = 5'd27;
    localparam logic [CODE_W-1:0] LTRS_CODE = 5'd31;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic              both;
        logic              fig;
        logic [CODE_W-1:0] code;
    } xl_entry_t;
endpackage

// File: rtl/baudot_xlate_rom.sv
module baudot_xlate_rom
    import baudot_pkg::*;
(
    input  logic [KEY_W-1:0] key_i,
    output xl_entry_t        entry_o
);
    logic [KEY_W-1:0] key_up;

    always_comb begin
        if (key_i >= 7'h61 && key_i <= 7'h7A) begin
            key_up = key_i - 7'h20;
        end else begin
            key_up = key_i;
        end
    end

    always_comb begin
        entry_o = '0;
        unique case (key_up)
            7'h41: entry_o = '{1'b0, 1'b0, 5'd24};
            7'h42: entry_o = '{1'b0, 1'b0, 5'd19};
            7'h43: entry_o = '{1'b0, 1'b0, 5'd14};
            7'h44: entry_o = '{1'b0, 1'b0, 5'd18};
            7'h45: entry_o = '{1'b0, 1'b0, 5'd16};
            7'h46: entry_o = '{1'b0, 1'b0, 5'd22};
            7'h47: entry_o = '{1'b0, 1'b0, 5'd11};
            7'h48: entry_o = '{1'b0, 1'b0, 5'd5};
            7'h49: entry_o = '{1'b0, 1'b0, 5'd12};
            7'h4A: entry_o = '{1'b0, 1'b0, 5'd26};
            7'h4B: entry_o = '{1'b0, 1'b0, 5'd30};
            7'h4C: entry_o = '{1'b0, 1'b0, 5'd9};
            7'h4D: entry_o = '{1'b0, 1'b0, 5'd7};
            7'h4E: entry_o = '{1'b0, 1'b0, 5'd6};
            7'h4F: entry_o = '{1'b0, 1'b0, 5'd3};
            7'h50: entry_o = '{1'b0, 1'b0, 5'd13};
            7'h51: entry_o = '{1'b0, 1'b0, 5'd29};
            7'h52: entry_o = '{1'b0, 1'b0, 5'd10};
            7'h53: entry_o = '{1'b0, 1'b0, 5'd20};
            7'h54: entry_o = '{1'b0, 1'b0, 5'd1};
            7'h55: entry_o = '{1'b0, 1'b0, 5'd28};
            7'h56: entry_o = '{1'b0, 1'b0, 5'd15};
            7'h57: entry_o = '{1'b0, 1'b0, 5'd25};
            7'h58: entry_o = '{1'b0, 1'b0, 5'd23};
            7'h59: entry_o = '{1'b0, 1'b0, 5'd21};
            7'h5A: entry_o = '{1'b0, 1'b0, 5'd17};
            7'h30: entry_o = '{1'b0, 1'b1, 5'd13};
            7'h31: entry_o = '{1'b0, 1'b1, 5'd29};
            7'h32: entry_o = '{1'b0, 1'b1, 5'd25};
            7'h33: entry_o = '{1'b0, 1'b1, 5'd16};
            7'h34: entry_o = '{1'b0, 1'b1, 5'd10};
            7'h35: entry_o = '{1'b0, 1'b1, 5'd1};
            7'h36: entry_o = '{1'b0, 1'b1, 5'd21};
            7'h37: entry_o = '{1'b0, 1'b1, 5'd28};
            7'h38: entry_o = '{1'b0, 1'b1, 5'd12};
            7'h39: entry_o = '{1'b0, 1'b1, 5'd3};
            7'h2D: entry_o = '{1'b0, 1'b1, 5'd24};
            7'h2E: entry_o = '{1'b0, 1'b1, 5'd7};
            7'h2C: entry_o = '{1'b0, 1'b1, 5'd6};
            7'h2F: entry_o = '{1'b0, 1'b1, 5'd23};
            7'h3F: entry_o = '{1'b0, 1'b1, 5'd19};
            7'h07: entry_o = '{1'b0, 1'b1, 5'd20};
            7'h20: entry_o = '{1'b1, 1'b0, 5'd4};
            7'h0D: entry_o = '{1'b1, 1'b0, 5'd2};
            7'h0A: entry_o = '{1'b1, 1'b0, 5'd8};
            default: entry_o = '0;
        endcase
    end
endmodule

// File: rtl/baudot_shift_fsm.sv
module baudot_shift_fsm
    import baudot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_i,
    input  logic              key_valid_i,
    input  xl_entry_t         entry_i,
    output logic              key_ready_o,
    output logic              deliver_o,
    output logic [CODE_W-1:0] deliver_code_o,
    output logic              shift_o
);
    seq_state_e        state_q, state_d;
    logic [CODE_W-1:0] pend_q, pend_d;
    logic              shift_q, shift_d;
    logic              accept;
    logic              mapped;
    logic              direct;

    assign accept = slot_i && key_valid_i && (state_q == ST_IDLE);
    assign mapped = (entry_i != '0);
    assign direct = entry_i.both || (entry_i.fig == shift_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            shift_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            shift_q <= shift_d;
        end
    end

    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        shift_d = shift_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && mapped && !direct) begin
                    state_d = ST_HOLD;
                    pend_d  = entry_i.code;
                    shift_d = entry_i.fig;
                end
            end
            ST_HOLD: begin
                if (slot_i) begin
                    state_d = ST_IDLE;
                    pend_d  = '0;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        key_ready_o    = 1'b0;
        deliver_o      = 1'b0;
        deliver_code_o = '0;
        unique case (state_q)
            ST_IDLE: begin
                key_ready_o = slot_i;
                if (accept && mapped) begin
                    deliver_o = 1'b1;
                    if (direct) begin
                        deliver_code_o = entry_i.code;
                    end else begin
                        deliver_code_o = entry_i.fig ? FIGS_CODE : LTRS_CODE;
                    end
                end
            end
            ST_HOLD: begin
                if (slot_i) begin
                    deliver_o      = 1'b1;
                    deliver_code_o = pend_q;
                end
            end
            default: ;
        endcase
    end

    assign shift_o = shift_q;

    assert_hold_stalls_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> !key_ready_o);
    assert_hold_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && slot_i) |=> (state_q == ST_IDLE));
    assert_shift_only_on_case_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(shift_q) |-> (state_q == ST_HOLD));
    assert_no_slot_no_delivery_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_i |-> (!deliver_o && !key_ready_o));
endmodule

// File: rtl/baudot_host_buf.sv
module baudot_host_buf
    import baudot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deliver_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              rd_i,
    output logic [CODE_W-1:0] buf_o,
    output logic              flag_o
);
    logic [CODE_W-1:0] buf_q;
    logic              flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q  <= '0;
            flag_q <= 1'b0;
        end else if (deliver_i) begin
            buf_q  <= code_i;
            flag_q <= 1'b1;
        end else if (rd_i) begin
            flag_q <= 1'b0;
        end
    end

    assign buf_o  = buf_q;
    assign flag_o = flag_q;

    assert_delivery_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        deliver_i |=> flag_q);
    assert_read_clears_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !deliver_i) |=> !flag_q);
    assert_buf_only_on_delivery_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(buf_q) |-> $past(deliver_i));
endmodule

// File: rtl/baudot_kbd_seq.sv
module baudot_kbd_seq
    import baudot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_i,
    input  logic              key_valid_i,
    input  logic [KEY_W-1:0]  key_code_i,
    output logic              key_ready_o,
    input  logic              rd_i,
    output logic [CODE_W-1:0] data_o,
    output logic              ready_flag_o,
    output logic              shift_fig_o
);
    xl_entry_t         entry;
    logic              deliver;
    logic [CODE_W-1:0] deliver_code;

    baudot_xlate_rom u_rom (
        .key_i   (key_code_i),
        .entry_o (entry)
    );

    baudot_shift_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .slot_i         (slot_i),
        .key_valid_i    (key_valid_i),
        .entry_i        (entry),
        .key_ready_o    (key_ready_o),
        .deliver_o      (deliver),
        .deliver_code_o (deliver_code),
        .shift_o        (shift_fig_o)
    );

    baudot_host_buf u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .deliver_i (deliver),
        .code_i    (deliver_code),
        .rd_i      (rd_i),
        .buf_o     (data_o),
        .flag_o    (ready_flag_o)
    );
endmodule

// File: tb/baudot_kbd_seq_tb.sv
module baudot_kbd_seq_tb;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_i = 1'b0;
    logic       key_valid_i = 1'b0;
    logic [6:0] key_code_i = '0;
    logic       key_ready_o;
    logic       rd_i = 1'b0;
    logic [4:0] data_o;
    logic       ready_flag_o;
    logic       shift_fig_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic kr_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    baudot_kbd_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_i       (slot_i),
        .key_valid_i  (key_valid_i),
        .key_code_i   (key_code_i),
        .key_ready_o  (key_ready_o),
        .rd_i         (rd_i),
        .data_o       (data_o),
        .ready_flag_o (ready_flag_o),
        .shift_fig_o  (shift_fig_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; applies inputs for one cycle, returns at next falling edge.
    task automatic step(input logic v, input logic [6:0] c, input logic s, input logic r);
        key_valid_i = v;
        key_code_i  = c;
        slot_i      = s;
        rd_i        = r;
        #1 kr_seen  = key_ready_o;
        @(negedge clk);
        key_valid_i = 1'b0;
        slot_i      = 1'b0;
        rd_i        = 1'b0;
    endtask

    task automatic read_host();
        step(1'b0, 7'h00, 1'b0, 1'b1);
    endtask

    task automatic t_reset();
        chk("R1 flag", ready_flag_o, 0);
        chk("R1 buffer", data_o, 0);
        chk("R1 shift", shift_fig_o, 0);
        chk("R1 key_ready", key_ready_o, 0);
    endtask

    task automatic t_direct_letter();
        step(1'b1, 7'h45, 1'b1, 1'b0);
        chk("R2 ready taken", kr_seen, 1);
        chk("R2 code E", data_o, 16);
        chk("R2 flag", ready_flag_o, 1);
        read_host();
        chk("R9 read clears", ready_flag_o, 0);
        step(1'b1, 7'h65, 1'b1, 1'b0);
        chk("R3 lower e", data_o, 16);
        read_host();
    endtask

    task automatic t_untranslatable();
        step(1'b1, 7'h40, 1'b1, 1'b0);
        chk("R4 flag", ready_flag_o, 0);
        chk("R4 buffer", data_o, 16);
        chk("R4 shift", shift_fig_o, 0);
    endtask

    task automatic t_to_figures();
        step(1'b1, 7'h33, 1'b1, 1'b0);
        chk("R6 FIGS code", data_o, 27);
        chk("R6 shift", shift_fig_o, 1);
        chk("R6 flag", ready_flag_o, 1);
        read_host();
        step(1'b0, 7'h00, 1'b0, 1'b0);
        chk("R10 no slot", ready_flag_o, 0);
        step(1'b0, 7'h00, 1'b1, 1'b0);
        chk("R6 held code", data_o, 16);
        chk("R6 held flag", ready_flag_o, 1);
        read_host();
        step(1'b1, 7'h35, 1'b1, 1'b0);
        chk("R11 direct figure", data_o, 1);
        chk("R11 shift kept", shift_fig_o, 1);
        read_host();
        step(1'b1, 7'h20, 1'b1, 1'b0);
        chk("R5 space", data_o, 4);
        chk("R5 shift figures", shift_fig_o, 1);
        step(1'b1, 7'h0D, 1'b1, 1'b0);
        chk("R5 CR", data_o, 2);
        read_host();
    endtask

    task automatic t_to_letters_with_stall();
        step(1'b1, 7'h54, 1'b1, 1'b0);
        chk("R7 LTRS code", data_o, 31);
        chk("R7 shift", shift_fig_o, 0);
        read_host();
        step(1'b1, 7'h45, 1'b1, 1'b0);
        chk("R8 stalled", kr_seen, 0);
        chk("R8 held first", data_o, 1);
        read_host();
        step(1'b1, 7'h45, 1'b1, 1'b0);
        chk("R8 later accepted", kr_seen, 1);
        chk("R8 later code", data_o, 16);
    endtask

    task automatic t_read_collision();
        step(1'b1, 7'h0A, 1'b1, 1'b1);
        chk("R9 collision flag", ready_flag_o, 1);
        chk("R5 LF", data_o, 8);
        chk("R5 shift letters", shift_fig_o, 0);
        read_host();
    endtask

    task automatic t_no_slot();
        step(1'b1, 7'h41, 1'b0, 1'b0);
        chk("R10 ready low", kr_seen, 0);
        chk("R10 flag", ready_flag_o, 0);
        chk("R10 buffer", data_o, 8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_direct_letter();
        t_untranslatable();
        t_to_figures();
        t_to_letters_with_stall();
        t_read_collision();
        t_no_slot();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule